// File: doc/BRIEF.md
# Extended Hamming Word Checker

This block checks a 64-bit protected word that holds 56 payload bits and 8 check bits, and repairs it. The word arrives as two 32-bit halves, the lower half holding word bits 31..0 and the upper half holding bits 63..32. A single-cycle strobe marks a new word. One clock later the block presents the repaired word, the 56-bit payload gathered from it, a 5-bit user-flag field taken from the repaired word, and a status: clean, repaired, or not repairable.

The check bits sit at word positions 0, 1, 2, 4, 8, 16, 32 and 63. The six positional check bits form a syndrome that gives the index of a flipped bit directly. Bit 0 is an overall parity over the payload. Bit 63 is a parity over the positional check bits alone. Together these two extra checks tell a single error apart from a double error. A companion encoder builds a valid protected word from 56 payload bits. It is used to produce test words.

Top module: `ehw_checker`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `out_clean`, `out_fixed` and `out_fatal` are 0 and `out_word` is all zeros until the first strobe.
- R2: A word with even parity on all eight checks is reported with `out_clean`=1 and `out_pos`=0, and `out_word` equals the input word.
- R3: A word with exactly one flipped payload bit at position p is reported with `out_fixed`=1 and `out_pos`=p, and `out_word` is the original clean word.
- R4: A word with exactly one flipped positional check bit (position 1, 2, 4, 8, 16 or 32) is repaired in the same way, and its payload is unchanged.
- R5: A single flip of bit 0 is reported as repaired at `out_pos`=0. A single flip of bit 63 is reported as repaired at `out_pos`=63. In both cases the payload is unchanged.
- R6: A word with two flipped bits (any pair, including bit 0 and bit 63) is reported with `out_fatal`=1 and `out_pos`=0, and `out_word` equals the input word unchanged.
- R7: Results appear on the first clock edge after the edge that samples `in_valid`=1. `out_valid` is high for exactly one cycle per strobe. Without a strobe, `out_word` and the status hold their values.
- R8: `out_flags` equals bits 62..58 of `out_word`, so a repaired flip inside that field yields the original flag value.
- R9: Whenever `out_valid` is 1, exactly one of `out_clean`, `out_fixed` and `out_fatal` is 1.
- R10: `in_lo` carries word bits 31..0 and `in_hi` carries bits 63..32. `out_data` bit i is the i-th non-check position in ascending order (positions 3, 5, 6, 7, 9, ..., 62).
- R11: The encoder places payload bit i at that same position and sets all eight check bits so that the checker reports the word as clean.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking a new word on `in_lo`/`in_hi` |
| in_lo | input | 32 | Word bits 31..0 |
| in_hi | input | 32 | Word bits 63..32 |
| out_valid | output | 1 | One-cycle pulse marking a fresh result |
| out_word | output | 64 | Repaired word (or input word when not repairable) |
| out_data | output | 56 | Payload gathered from `out_word` |
| out_flags | output | 5 | User-flag field, bits 62..58 of `out_word` |
| out_pos | output | 6 | Index of the repaired bit, 0 unless repaired at a nonzero index |
| out_clean | output | 1 | No error found |
| out_fixed | output | 1 | Single error repaired |
| out_fatal | output | 1 | Double error, word passed through |

## Verification
Two functions can act on the same result: bit repair and flag extraction both touch the flag field. A single flip placed at each of positions 58 to 62 must come back with the flags equal to the clean value. A double error inside the field must leave the corrupted flags visible. The bench also sends strobes back to back, so that a new result replaces the previous one on consecutive cycles. It checks that each cycle carries its own word's status, and that the outputs freeze once the strobes stop.

// File: rtl/ehw_pkg.sv
package ehw_pkg;

    localparam int unsigned SYN_W    = 6;
    localparam int unsigned WORD_W   = 1 << SYN_W;
    localparam int unsigned DATA_W   = WORD_W - SYN_W - 2;
    localparam int unsigned HALF_W   = WORD_W / 2;
    localparam int unsigned FLAG_W   = 5;
    localparam int unsigned FLAG_LSB = WORD_W - 1 - FLAG_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [SYN_W-1:0]  syn_t;

    typedef enum logic [1:0] {
        CHK_IDLE,
        CHK_CLEAN,
        CHK_FIXED,
        CHK_FATAL
    } chk_state_e;

    // word position holding payload bit idx (ascending non-check positions)
    function automatic int unsigned data_pos(int unsigned idx);
        int unsigned seen = 0;
        for (int unsigned p = 1; p < WORD_W - 1; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == idx) return p;
                seen++;
            end
        end
        return 0;
    endfunction

    // positions 1..WORD_W-2 whose index has weight 2**k set
    function automatic word_t cover_mask(int unsigned k);
        word_t m = '0;
        for (int unsigned p = 1; p < WORD_W - 1; p++) begin
            if (((p >> k) & 1) == 1) m = m | (word_t'(1) << p);
        end
        return m;
    endfunction

    function automatic word_t payload_mask();
        word_t m = '0;
        for (int unsigned p = 1; p < WORD_W - 1; p++) begin
            if ((p & (p - 1)) != 0) m = m | (word_t'(1) << p);
        end
        return m;
    endfunction

    function automatic word_t positional_mask();
        word_t m = '0;
        for (int unsigned k = 0; k < SYN_W; k++) m = m | (word_t'(1) << (1 << k));
        return m;
    endfunction

    localparam word_t PAYLOAD_MASK = payload_mask();
    localparam word_t POSCHK_MASK  = positional_mask();
    localparam word_t OVERALL_MASK = PAYLOAD_MASK | word_t'(1);
    localparam word_t TOPCHK_MASK  = POSCHK_MASK | (word_t'(1) << (WORD_W - 1));

endpackage

// File: rtl/ehw_encode.sv
module ehw_encode
    import ehw_pkg::*;
(
    input  data_t d,
    output word_t w
);

    word_t spread;
    syn_t  chk;

    for (genvar i = 0; i < DATA_W; i++) begin : g_spread
        assign spread[data_pos(i)] = d[i];
    end
    assign spread[0]        = 1'b0;
    assign spread[WORD_W-1] = 1'b0;
    for (genvar k = 0; k < SYN_W; k++) begin : g_zero
        assign spread[1 << k] = 1'b0;
    end

    for (genvar k = 0; k < SYN_W; k++) begin : g_chk
        assign chk[k] = ^(spread & cover_mask(k));
    end

    always_comb begin
        w = spread;
        for (int k = 0; k < SYN_W; k++) begin
            w = w | (word_t'(chk[k]) << (1 << k));
        end
        w[0]        = ^d;
        w[WORD_W-1] = ^chk;
    end

endmodule

// File: rtl/ehw_syndrome.sv
module ehw_syndrome
    import ehw_pkg::*;
(
    input  word_t w,
    output syn_t  syn,
    output logic  overall_odd,
    output logic  top_odd
);

    for (genvar k = 0; k < SYN_W; k++) begin : g_syn
        assign syn[k] = ^(w & cover_mask(k));
    end

    assign overall_odd = ^(w & OVERALL_MASK);
    assign top_odd     = ^(w & TOPCHK_MASK);

endmodule

// File: rtl/ehw_locate.sv
module ehw_locate
    import ehw_pkg::*;
(
    input  syn_t       syn,
    input  logic       overall_odd,
    input  logic       top_odd,
    output chk_state_e verdict,
    output syn_t       flip_idx,
    output word_t      flip_mask
);

    logic hit;

    always_comb begin
        verdict  = CHK_CLEAN;
        flip_idx = '0;
        hit      = 1'b0;
        if (overall_odd ^ top_odd) begin
            // exactly one extra check odd: single error
            verdict  = CHK_FIXED;
            hit      = 1'b1;
            flip_idx = syn;
            if (top_odd && (syn == '0)) flip_idx = '1;
        end else if (overall_odd || (syn != '0)) begin
            verdict = CHK_FATAL;
        end
    end

    assign flip_mask = hit ? (word_t'(1) << flip_idx) : '0;

endmodule

// File: rtl/ehw_checker.sv
module ehw_checker
    import ehw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [HALF_W-1:0]   in_lo,
    input  logic [HALF_W-1:0]   in_hi,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_word,
    output logic [DATA_W-1:0]   out_data,
    output logic [FLAG_W-1:0]   out_flags,
    output logic [SYN_W-1:0]    out_pos,
    output logic                out_clean,
    output logic                out_fixed,
    output logic                out_fatal
);

    word_t      raw;
    syn_t       syn;
    logic       overall_odd;
    logic       top_odd;
    chk_state_e verdict;
    syn_t       flip_idx;
    word_t      flip_mask;

    word_t      word_q;
    syn_t       pos_q;
    chk_state_e state_q;
    logic       valid_q;

    assign raw = {in_hi, in_lo};

    ehw_syndrome u_syn (
        .w           (raw),
        .syn         (syn),
        .overall_odd (overall_odd),
        .top_odd     (top_odd)
    );

    ehw_locate u_loc (
        .syn         (syn),
        .overall_odd (overall_odd),
        .top_odd     (top_odd),
        .verdict     (verdict),
        .flip_idx    (flip_idx),
        .flip_mask   (flip_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
            pos_q   <= '0;
            state_q <= CHK_IDLE;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                word_q  <= raw ^ flip_mask;
                pos_q   <= flip_idx;
                state_q <= verdict;
            end
        end
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_gather
        assign out_data[i] = word_q[data_pos(i)];
    end

    assign out_valid = valid_q;
    assign out_word  = word_q;
    assign out_flags = word_q[FLAG_LSB +: FLAG_W];
    assign out_pos   = pos_q;
    assign out_clean = (state_q == CHK_CLEAN);
    assign out_fixed = (state_q == CHK_FIXED);
    assign out_fatal = (state_q == CHK_FATAL);

    // R7: result pulse follows the strobe by one edge
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_word) && $stable(out_pos)));

    // R9: one status per result
    a_r9_one_status: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones({out_clean, out_fixed, out_fatal}) == 1));

    // R3: a repair changes exactly one bit of the input word
    a_r3_single_flip: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_fixed == ($countones(out_word ^ $past(raw)) == 1)));

    // R6: a word that is not repaired passes through unchanged
    a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_fixed || (out_word == $past(raw))));

    // R6: a fatal verdict reports no position
    a_r6_fatal_no_pos: assert property (@(posedge clk) disable iff (rst)
        (in_valid && verdict == CHK_FATAL) |=> (out_fatal && out_pos == '0));

endmodule

// File: tb/ehw_checker_test.sv
`timescale 1ns/1ps
module ehw_checker_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_lo;
    logic [31:0] in_hi;
    logic        out_valid;
    logic [63:0] out_word;
    logic [55:0] out_data;
    logic [4:0]  out_flags;
    logic [5:0]  out_pos;
    logic        out_clean;
    logic        out_fixed;
    logic        out_fatal;
    logic [55:0] gen_d;
    logic [63:0] gen_w;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ehw_checker uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_lo     (in_lo),
        .in_hi     (in_hi),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_data  (out_data),
        .out_flags (out_flags),
        .out_pos   (out_pos),
        .out_clean (out_clean),
        .out_fixed (out_fixed),
        .out_fatal (out_fatal)
    );

    ehw_encode gen_u (
        .d (gen_d),
        .w (gen_w)
    );

    function automatic logic [63:0] ref_enc(input logic [55:0] d);
        logic [63:0] w = '0;
        int k = 0;
        for (int p = 1; p < 63; p++) begin
            if ((p & (p - 1)) != 0) begin
                w[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 6; b++) begin
            logic x = 1'b0;
            for (int p = 1; p < 63; p++) if (p[b]) x ^= w[p];
            w[1 << b] = x;
        end
        w[0]  = ^d;
        w[63] = w[1] ^ w[2] ^ w[4] ^ w[8] ^ w[16] ^ w[32];
        return w;
    endfunction

    function automatic logic [55:0] ref_gather(input logic [63:0] w);
        logic [55:0] d = '0;
        int k = 0;
        for (int p = 1; p < 63; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = w[p];
                k++;
            end
        end
        return d;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one word, return after the result is registered (at a negedge)
    task automatic send(input logic [63:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_lo    = w[31:0];
        in_hi    = w[63:32];
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // st: 0 clean, 1 fixed, 2 fatal
    task automatic expect_out(input string req, input logic [63:0] exp_w,
                              input int st, input logic [5:0] pos);
        chk(req, "valid", 64'(out_valid), 64'd1);
        chk("R9", "status", 64'({out_clean, out_fixed, out_fatal}),
            64'((st == 0) ? 3'b100 : (st == 1) ? 3'b010 : 3'b001));
        chk(req, "word", out_word, exp_w);
        chk("R10", "data", 64'(out_data), 64'(ref_gather(exp_w)));
        chk("R8", "flags", 64'(out_flags), 64'(exp_w[62:58]));
        chk(req, "pos", 64'(out_pos), 64'(pos));
    endtask

    task automatic t_reset();
        chk("R1", "valid", 64'(out_valid), 64'd0);
        chk("R1", "status", 64'({out_clean, out_fixed, out_fatal}), 64'd0);
        chk("R1", "word", out_word, 64'd0);
    endtask

    task automatic t_clean();
        logic [55:0] pats [5];
        pats[0] = 56'h0;
        pats[1] = {56{1'b1}};
        pats[2] = 56'hAA_5555_AAAA_5555;
        pats[3] = 56'h12_3456_789A_BCDE;
        pats[4] = 56'h80_0000_0000_0001;
        for (int i = 0; i < 5; i++) begin
            logic [63:0] w = ref_enc(pats[i]);
            gen_d = pats[i];
            #1;
            chk("R11", "encoder", gen_w, w);
            send(w);
            expect_out("R2", w, 0, 6'd0);
        end
    endtask

    task automatic t_data_single();
        logic [63:0] w = ref_enc(56'h5A_0F1E_2D3C_4B69);
        for (int p = 1; p < 63; p++) begin
            if ((p & (p - 1)) != 0) begin
                send(w ^ (64'd1 << p));
                expect_out("R3", w, 1, 6'(p));
            end
        end
    endtask

    task automatic t_check_single();
        logic [63:0] w = ref_enc(56'hC3_A5A5_0000_FFFF);
        for (int b = 0; b < 6; b++) begin
            send(w ^ (64'd1 << (1 << b)));
            expect_out("R4", w, 1, 6'(1 << b));
        end
    endtask

    task automatic t_edge_single();
        logic [63:0] w = ref_enc(56'h01_2345_6789_ABCD);
        send(w ^ 64'd1);
        expect_out("R5", w, 1, 6'd0);
        send(w ^ (64'd1 << 63));
        expect_out("R5", w, 1, 6'd63);
    endtask

    task automatic t_double();
        int pa [9] = '{3, 1, 16, 0, 63, 0, 0, 63, 12};
        int pb [9] = '{5, 2, 40, 7, 9, 63, 4, 32, 50};
        logic [63:0] w = ref_enc(56'hFE_DCBA_9876_5432);
        for (int i = 0; i < 9; i++) begin
            logic [63:0] bw = w ^ (64'd1 << pa[i]) ^ (64'd1 << pb[i]);
            send(bw);
            expect_out("R6", bw, 2, 6'd0);
        end
    endtask

    task automatic t_flags();
        logic [55:0] d = 56'h0;
        logic [63:0] w;
        logic [63:0] bw;
        d[55:51] = 5'b10110;
        w = ref_enc(d);
        chk("R8", "encoded flags", 64'(w[62:58]), 64'd22);
        for (int p = 58; p < 63; p++) begin
            send(w ^ (64'd1 << p));
            chk("R8", "repaired flags", 64'(out_flags), 64'd22);
            chk("R8", "fixed", 64'(out_fixed), 64'd1);
        end
        bw = w ^ (64'd1 << 59) ^ (64'd1 << 30);
        send(bw);
        chk("R8", "fatal flags", 64'(out_flags), 64'(bw[62:58]));
        chk("R6", "fatal", 64'(out_fatal), 64'd1);
    endtask

    task automatic t_halves();
        logic [63:0] w = ref_enc(56'h33_CCCC_3333_CCCC);
        send(w ^ (64'd1 << 31));
        expect_out("R10", w, 1, 6'd31);
        send(w ^ (64'd1 << 33));
        expect_out("R10", w, 1, 6'd33);
    endtask

    task automatic t_timing();
        logic [63:0] wa = ref_enc(56'h11_1111_1111_1111);
        logic [63:0] wb = ref_enc(56'h22_2222_2222_2222) ^ (64'd1 << 44);
        logic [63:0] wc = ref_enc(56'h44_4444_4444_4444) ^ 64'h3;
        @(negedge clk);
        in_valid = 1'b1;
        in_lo = wa[31:0]; in_hi = wa[63:32];
        #1;
        chk("R7", "no early valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk("R7", "valid a", 64'(out_valid), 64'd1);
        chk("R7", "word a", out_word, wa);
        chk("R7", "clean a", 64'(out_clean), 64'd1);
        in_lo = wb[31:0]; in_hi = wb[63:32];
        @(negedge clk);
        chk("R7", "valid b", 64'(out_valid), 64'd1);
        chk("R7", "fixed b", 64'(out_fixed), 64'd1);
        chk("R7", "pos b", 64'(out_pos), 64'd44);
        in_lo = wc[31:0]; in_hi = wc[63:32];
        @(negedge clk);
        chk("R7", "fatal c", 64'(out_fatal), 64'd1);
        chk("R7", "word c", out_word, wc);
        in_valid = 1'b0;
        in_lo = 32'hDEAD_BEEF; in_hi = 32'h0BAD_F00D;
        @(negedge clk);
        chk("R7", "pulse ends", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk("R7", "hold word", out_word, wc);
        chk("R7", "hold status", 64'(out_fatal), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_lo = '0;
        in_hi = '0;
        gen_d = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_clean();
        t_data_single();
        t_check_single();
        t_edge_single();
        t_double();
        t_flags();
        t_halves();
        t_timing();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule